// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged L1 Data Cache Lookup

This block is the read lookup path of a small L1 data cache. It picks the set from the page-offset bits of the virtual address, which do not change under translation, so the four tags of that set can be read while the translation unit is still working on the page number. When the translation result arrives with its physical page number, that number is compared against the captured tags. A match returns one 32-bit word. A mismatch sends a line request to the next level and waits for the refill.

The cache holds 16 KB: 128 sets, each with 4 ways of 32-byte lines. A physical address is taken apart as bits [31:12] tag, bits [11:5] set and bits [4:0] byte offset. Replacement uses a three-bit pseudo-LRU tree for each set. A page marked cache-disabled by its translation skips the array entirely. Its data comes back through the refill port and no line is allocated for it. The block accepts one outstanding read at a time and holds the processor off with a stall until the answer is out.

Top module: `vipt_l1_cache`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, `rsp_valid`, `miss_valid` and `req_stall` are 0. Every line starts invalid, so the first access to any set misses.
- R2: A request is accepted when `req_valid` is 1 and `req_stall` is 0. From the next cycle, `req_stall` stays 1 until the cycle in which the response is presented, and it is 0 in that cycle. A `req_valid` seen while stalled is ignored.
- R3: The set comes from virtual address bits [11:5] when the request is accepted. A hit means a valid way whose stored tag equals `xlat_ppn`, and the virtual page number plays no part. On a hit, `rsp_valid` pulses in the cycle after the cycle in which `xlat_valid` is seen. `rsp_data` then holds the 32-bit word at bits [32*k+31:32*k] of the line, where k = address bits [4:2].
- R4: On a miss, `miss_valid` pulses for one cycle in the cycle after `xlat_valid`. In that pulse, `miss_paddr` = {`xlat_ppn`, virtual address bits [11:0]} and `miss_bypass` = 0. `rsp_valid` and `miss_valid` are never 1 together.
- R5: After a miss, the first `fill_valid` carries the whole 256-bit line in `fill_data`. In the next cycle, `rsp_valid` pulses with the word selected as in R3. The line is written into the way chosen by R6, that way is marked valid, and later reads of the line hit.
- R6: Each set has tree bits t0..t2, all 0 after reset. t0=0 picks ways 0–1 as the victim half and t0=1 picks ways 2–3. Within the lower pair, t1=0 picks way 0 and t1=1 picks way 1. Within the upper pair, t2=0 picks way 2 and t2=1 picks way 3. Every hit and every fill sets the bits on the touched way's path so that they point away from that way.
- R7: When `xlat_nocache` is 1 with `xlat_valid`, the access is always treated as a miss with `miss_bypass` = 1, even if the line is cached. The response word is taken from the refill data. Nothing is allocated and the replacement bits do not change.
- R8: `xlat_valid` outside the wait for translation has no effect, and neither does `fill_valid` outside the wait for a refill. No response and no miss request result from either, and the cache contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor read request |
| req_vaddr | input | 32 | Virtual byte address of the read |
| req_stall | output | 1 | High while a read is in progress; new requests are not taken |
| xlat_valid | input | 1 | Translation result strobe |
| xlat_ppn | input | 20 | Physical page number from translation |
| xlat_nocache | input | 1 | Page cache-disable attribute |
| rsp_valid | output | 1 | One-cycle pulse: read data ready |
| rsp_data | output | 32 | Returned word |
| miss_valid | output | 1 | One-cycle pulse: request to next level |
| miss_paddr | output | 32 | Physical address of the requested word |
| miss_bypass | output | 1 | Request is uncached; refill will not be allocated |
| fill_valid | input | 1 | Refill line strobe |
| fill_data | input | 256 | Refill line, word k at bits [32k+31:32k] |

## Verification
`req_stall` rises one cycle after the acceptance edge. A hit response or a miss request appears one cycle after the edge that sees `xlat_valid`. A refill response appears one cycle after the edge that sees `fill_valid`. The bench drives every input on the falling edge and samples each result on the falling edge that follows its due rising edge, never earlier or later. It sweeps all 128 sets with varied translation and refill delays, keeps an arithmetic model of tags, valid bits and tree bits to predict hit or miss, and derives the expected word from a formula of physical line address and word index. Stray requests, strobes and refills are issued while the block is busy or idle to confirm they are ignored.

// File: rtl/vipt_pkg.sv
// Shared types for the VIPT L1 lookup path.
// Assumes: one outstanding read at a time.
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // ready for a new read
        ST_XLAT = 2'd1,   // tags captured, waiting for physical page number
        ST_FILL = 2'd2    // miss issued, waiting for the line
    } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
// Tag and valid-bit arrays for all ways of every set.
// Read is combinational on the set index so the tags can be captured in the
// cycle the request is accepted. One write port allocates a way on refill.
// Assumes: only valid bits need reset; tag contents are don't-care until valid.
module vipt_tag_store #(
    parameter int SET_W = 7,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_vld,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [$clog2(WAYS)-1:0]     wr_way,
    input  logic [TAG_W-1:0]            wr_tag
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    // Combinational read of every way's tag and valid bit for one set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tags[w] = tag_q[rd_set][w];
        end
        rd_vld = vld_q[rd_set];
    end

    // Tag array write on allocation.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

    // Valid bits: cleared by reset, set on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
        end
    end
endmodule

// File: rtl/vipt_data_store.sv
// Line data array, one entry per (set, way).
// Combinational word read; whole-line write on refill.
// Assumes: line width is a whole number of words.
module vipt_data_store #(
    parameter int SET_W  = 7,
    parameter int WAYS   = 4,
    parameter int LINE_W = 256,
    parameter int WORD_W = 32
) (
    input  logic                          clk,
    input  logic [SET_W-1:0]              rd_set,
    input  logic [$clog2(WAYS)-1:0]       rd_way,
    input  logic [$clog2(LINE_W/WORD_W)-1:0] rd_word,
    output logic [WORD_W-1:0]             rd_data,
    input  logic                          wr_en,
    input  logic [SET_W-1:0]              wr_set,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic [LINE_W-1:0]             wr_line
);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int ENTRIES = (1 << SET_W) * WAYS;

    logic [LINE_W-1:0] line_q [ENTRIES];

    // Word select from the addressed line.
    always_comb begin
        rd_data = line_q[{rd_set, rd_way}][int'(rd_word) * WORD_W +: WORD_W];
    end

    // Whole-line write on refill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[{wr_set, wr_way}] <= wr_line;
        end
    end
endmodule

// File: rtl/vipt_plru.sv
// Tree pseudo-LRU state, WAYS-1 bits per set.
// Node 0 is the root; node n has children 2n+1 (bit 0) and 2n+2 (bit 1).
// A node bit of 0 sends the victim walk to its lower child. Touching a way
// flips each node on its path to point away from it. Reset clears all bits.
// Assumes: WAYS is a power of two, at least 2.
module vipt_plru #(
    parameter int SET_W = 7,
    parameter int WAYS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SET_W-1:0]        vic_set,
    output logic [$clog2(WAYS)-1:0] vic_way,
    input  logic                    upd_en,
    input  logic [SET_W-1:0]        upd_set,
    input  logic [$clog2(WAYS)-1:0] upd_way
);
    localparam int SETS  = 1 << SET_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int NODES = WAYS - 1;

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] tree_nx;

    // Walk the tree of the requested set to the victim leaf.
    always_comb begin
        int node;
        node    = 0;
        vic_way = '0;
        for (int l = 0; l < WAY_W; l++) begin
            vic_way = (vic_way << 1) | WAY_W'(tree_q[vic_set][node]);
            node    = 2 * node + 1 + int'(tree_q[vic_set][node]);
        end
    end

    // Next tree value after touching upd_way.
    always_comb begin
        int   node;
        logic b;
        tree_nx = tree_q[upd_set];
        node    = 0;
        for (int l = 0; l < WAY_W; l++) begin
            b             = upd_way[WAY_W-1-l];
            tree_nx[node] = ~b;
            node          = 2 * node + 1 + int'(b);
        end
    end

    // Tree state register per set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (upd_en) begin
            tree_q[upd_set] <= tree_nx;
        end
    end
endmodule

// File: rtl/vipt_l1_cache.sv
// Lookup path of a virtually-indexed, physically-tagged L1 data cache.
// On acceptance the set is taken from page-offset bits of the virtual address
// and all way tags are captured while translation proceeds elsewhere. The
// physical page number then selects the hitting way. Misses and uncached
// accesses go to the next level; refills return through fill_data.
// Assumes: index and offset bits fit inside the page offset (SET_W+OFF_W
// no larger than the page-offset width); one read outstanding.
module vipt_l1_cache #(
    parameter int ADDR_W = 32,
    parameter int SET_W  = 7,
    parameter int OFF_W  = 5,
    parameter int WAYS   = 4,
    parameter int WORD_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [ADDR_W-1:0]               req_vaddr,
    output logic                            req_stall,
    input  logic                            xlat_valid,
    input  logic [ADDR_W-SET_W-OFF_W-1:0]   xlat_ppn,
    input  logic                            xlat_nocache,
    output logic                            rsp_valid,
    output logic [WORD_W-1:0]               rsp_data,
    output logic                            miss_valid,
    output logic [ADDR_W-1:0]               miss_paddr,
    output logic                            miss_bypass,
    input  logic                            fill_valid,
    input  logic [8*(1<<OFF_W)-1:0]         fill_data
);
    import vipt_pkg::*;

    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int LINE_W = 8 * (1 << OFF_W);
    localparam int WPL    = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WPL);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int BOFF_W = OFF_W - WSEL_W;

    vipt_state_e                state_q;
    logic [SET_W-1:0]           hold_set;
    logic [OFF_W-1:0]           hold_off;
    logic [WAYS-1:0][TAG_W-1:0] hold_tags;
    logic [WAYS-1:0]            hold_vld;
    logic [TAG_W-1:0]           hold_ppn;
    logic                       hold_nc;

    logic [WAYS-1:0][TAG_W-1:0] rd_tags;
    logic [WAYS-1:0]            rd_vld;
    logic [WAYS-1:0]            hit_vec;
    logic                       any_hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           vic_way;
    logic [WORD_W-1:0]          arr_word;
    logic [WORD_W-1:0]          fill_word;
    logic [WSEL_W-1:0]          word_sel;

    logic                       accept;
    logic                       do_hit;
    logic                       do_alloc;
    logic                       plru_upd;
    logic [WAY_W-1:0]           plru_way;

    assign word_sel = hold_off[OFF_W-1:BOFF_W];
    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign req_stall = (state_q != ST_IDLE);

    // Per-way physical tag compare against the captured tags.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = hold_vld[w] && (hold_tags[w] == xlat_ppn);
    end

    // Encode the hitting way (at most one way can match).
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        any_hit = |hit_vec;
    end

    // Hit when translation lands in the wait state for a cacheable page.
    assign do_hit   = (state_q == ST_XLAT) && xlat_valid && !xlat_nocache && any_hit;
    // Allocate when the refill for a cacheable miss arrives.
    assign do_alloc = (state_q == ST_FILL) && fill_valid && !hold_nc;
    assign plru_upd = do_hit || do_alloc;
    assign plru_way = do_hit ? hit_way : vic_way;

    // Word selected from the refill line.
    assign fill_word = fill_data[int'(word_sel) * WORD_W +: WORD_W];

    vipt_tag_store #(
        .SET_W (SET_W),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (req_vaddr[OFF_W +: SET_W]),
        .rd_tags (rd_tags),
        .rd_vld  (rd_vld),
        .wr_en   (do_alloc),
        .wr_set  (hold_set),
        .wr_way  (vic_way),
        .wr_tag  (hold_ppn)
    );

    vipt_data_store #(
        .SET_W  (SET_W),
        .WAYS   (WAYS),
        .LINE_W (LINE_W),
        .WORD_W (WORD_W)
    ) u_data (
        .clk     (clk),
        .rd_set  (hold_set),
        .rd_way  (hit_way),
        .rd_word (word_sel),
        .rd_data (arr_word),
        .wr_en   (do_alloc),
        .wr_set  (hold_set),
        .wr_way  (vic_way),
        .wr_line (fill_data)
    );

    vipt_plru #(
        .SET_W (SET_W),
        .WAYS  (WAYS)
    ) u_plru (
        .clk     (clk),
        .rst_n   (rst_n),
        .vic_set (hold_set),
        .vic_way (vic_way),
        .upd_en  (plru_upd),
        .upd_set (hold_set),
        .upd_way (plru_way)
    );

    // Lookup sequencer: capture, compare, request, refill, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hold_set    <= '0;
            hold_off    <= '0;
            hold_tags   <= '0;
            hold_vld    <= '0;
            hold_ppn    <= '0;
            hold_nc     <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
            miss_valid  <= 1'b0;
            miss_paddr  <= '0;
            miss_bypass <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            miss_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        hold_set  <= req_vaddr[OFF_W +: SET_W];
                        hold_off  <= req_vaddr[OFF_W-1:0];
                        hold_tags <= rd_tags;
                        hold_vld  <= rd_vld;
                        state_q   <= ST_XLAT;
                    end
                end
                ST_XLAT: begin
                    if (xlat_valid) begin
                        hold_ppn <= xlat_ppn;
                        hold_nc  <= xlat_nocache;
                        if (do_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= arr_word;
                            state_q   <= ST_IDLE;
                        end else begin
                            miss_valid  <= 1'b1;
                            miss_paddr  <= {xlat_ppn, hold_set, hold_off};
                            miss_bypass <= xlat_nocache;
                            state_q     <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (fill_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= fill_word;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vipt_l1_checker.sv
// Protocol checks on the lookup path's ports, bound to the top module.
// Assumes: synchronous active-low reset; one read outstanding.
module vipt_l1_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              req_stall,
    input logic              rsp_valid,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_paddr
);
    logic [11:0] acc_pgoff;

    // Remember the page offset of the accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_pgoff <= '0;
        else if (req_valid && !req_stall) acc_pgoff <= req_vaddr[11:0];
    end

    AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_stall) |=> req_stall) else $error("stall"); // R2
    AST_STALL_ENDS_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_stall) |-> rsp_valid) else $error("stall end"); // R2
    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("rsp pulse"); // R3
    AST_MISS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> !miss_valid) else $error("miss pulse"); // R4
    AST_RSP_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && miss_valid)) else $error("rsp and miss"); // R4
    AST_MISS_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (miss_paddr[11:0] == acc_pgoff)) else $error("miss addr"); // R4
    AST_MISS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> req_stall) else $error("miss idle"); // R5
endmodule

bind vipt_l1_cache vipt_l1_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_stall  (req_stall),
    .rsp_valid  (rsp_valid),
    .miss_valid (miss_valid),
    .miss_paddr (miss_paddr)
);

// File: tb/vipt_l1_cache_tb.sv
// Self-checking bench: sweeps every set, exercises replacement, uncached
// accesses and stray strobes against an arithmetic model.
module vipt_l1_cache_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         req_stall;
    logic         xlat_valid = 1'b0;
    logic [19:0]  xlat_ppn = '0;
    logic         xlat_nocache = 1'b0;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic         miss_valid;
    logic [31:0]  miss_paddr;
    logic         miss_bypass;
    logic         fill_valid = 1'b0;
    logic [255:0] fill_data = '0;

    int checks = 0;
    int errors = 0;

    logic [19:0] mtag [128][4];
    bit          mvld [128][4];
    logic [2:0]  mtree [128];

    always #5 clk = ~clk;

    vipt_l1_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_stall(req_stall), .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
        .xlat_nocache(xlat_nocache), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .miss_valid(miss_valid), .miss_paddr(miss_paddr), .miss_bypass(miss_bypass),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] fword(input logic [19:0] ppn, input logic [6:0] set,
                                          input logic [2:0] w, input bit nc);
        return {ppn[11:0], set, w, nc ? 10'h15A : 10'h2A5};
    endfunction

    function automatic logic [255:0] fline(input logic [19:0] ppn, input logic [6:0] set, input bit nc);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = fword(ppn, set, 3'(i), nc);
        return l;
    endfunction

    // Victim from tree bits per R6.
    function automatic logic [1:0] mvic(input logic [2:0] t);
        if (!t[0]) return t[1] ? 2'd1 : 2'd0;
        return t[2] ? 2'd3 : 2'd2;
    endfunction

    // Tree update per R6: path bits point away from the touched way.
    function automatic logic [2:0] mupd(input logic [2:0] t, input logic [1:0] w);
        logic [2:0] n;
        n = t;
        n[0] = (w < 2);
        if (w == 0) n[1] = 1'b1;
        if (w == 1) n[1] = 1'b0;
        if (w == 2) n[2] = 1'b1;
        if (w == 3) n[2] = 1'b0;
        return n;
    endfunction

    task automatic access(input logic [31:0] va, input logic [19:0] ppn, input bit nc,
                          input int d, input int d2);
        logic [6:0] set;
        logic [2:0] ws;
        bit         hit;
        logic [1:0] hw;
        logic [1:0] v;
        set = va[11:5];
        ws  = va[4:2];
        hit = 1'b0;
        hw  = '0;
        for (int w = 0; w < 4; w++)
            if (mvld[set][w] && mtag[set][w] == ppn) begin hit = 1'b1; hw = 2'(w); end
        if (nc) hit = 1'b0;

        @(negedge clk);
        chk(!req_stall, "R2 idle before request", 32'(req_stall), 0);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_stall, "R2 stall after accept", 32'(req_stall), 1);
        if (d > 0) begin
            req_valid = 1'b1; req_vaddr = ~va;   // stray request while stalled
            repeat (d) @(negedge clk);
            chk(req_stall && !rsp_valid && !miss_valid, "R2 waiting for translation",
                {29'b0, req_stall, rsp_valid, miss_valid}, 32'h4);
        end
        req_valid = 1'b0;
        xlat_valid = 1'b1; xlat_ppn = ppn; xlat_nocache = nc;
        @(negedge clk);
        xlat_valid = 1'b0; xlat_nocache = 1'b0;
        if (hit) begin
            chk(rsp_valid && !miss_valid, "R3 hit response", {30'b0, rsp_valid, miss_valid}, 32'h2);
            chk(rsp_data == fword(ppn, set, ws, 1'b0), "R3 hit data", rsp_data, fword(ppn, set, ws, 1'b0));
            chk(!req_stall, "R2 stall released with response", 32'(req_stall), 0);
            mtree[set] = mupd(mtree[set], hw);
        end else begin
            chk(miss_valid && !rsp_valid, "R4 miss request", {30'b0, rsp_valid, miss_valid}, 32'h1);
            chk(miss_paddr == {ppn, va[11:0]}, "R4 miss address", miss_paddr, {ppn, va[11:0]});
            chk(miss_bypass == nc, nc ? "R7 bypass flag" : "R4 bypass flag", 32'(miss_bypass), 32'(nc));
            if (d2 > 0) begin
                repeat (d2) @(negedge clk);
                chk(!miss_valid && !rsp_valid && req_stall, "R5 waiting for refill",
                    {29'b0, req_stall, rsp_valid, miss_valid}, 32'h4);
            end
            fill_valid = 1'b1; fill_data = fline(ppn, set, nc);
            @(negedge clk);
            fill_valid = 1'b0;
            chk(rsp_valid, "R5 refill response", 32'(rsp_valid), 1);
            chk(rsp_data == fword(ppn, set, ws, nc), nc ? "R7 bypass data" : "R5 refill data",
                rsp_data, fword(ppn, set, ws, nc));
            chk(!req_stall, "R2 stall released after refill", 32'(req_stall), 0);
            if (!nc) begin
                v = mvic(mtree[set]);
                mtag[set][v] = ppn;
                mvld[set][v] = 1'b1;
                mtree[set]   = mupd(mtree[set], v);
            end
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 128; s++) begin
            mtree[s] = '0;
            for (int w = 0; w < 4; w++) begin mvld[s][w] = 1'b0; mtag[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !miss_valid && !req_stall, "R1 outputs in reset",
            {29'b0, req_stall, rsp_valid, miss_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !miss_valid && !req_stall, "R1 outputs after reset",
            {29'b0, req_stall, rsp_valid, miss_valid}, 0);

        // R1/R3/R5: every set misses first, then hits on another word, with a different virtual page.
        for (int s = 0; s < 128; s++) begin
            access({20'hABC00 + 20'(s), 7'(s), 5'(4 * (s % 8))}, 20'h00100 + 20'(s), 1'b0, s % 3, (s + 1) % 3);
            access({20'h12300, 7'(s), 5'(4 * ((s + 3) % 8))}, 20'h00100 + 20'(s), 1'b0, (s + 2) % 3, 0);
        end

        // R6: replacement order on one set, pattern mixing hits and misses.
        for (int k = 0; k < 40; k++) begin
            access({20'h0, 7'd5, 5'(4 * (k % 8))}, 20'h00300 + 20'((k * 3 + k / 7) % 7), 1'b0, k % 2, k % 2);
        end
        for (int k = 0; k < 24; k++) begin
            access({20'h0, 7'd77, 5'd8}, 20'h00400 + 20'((k * 5) % 6), 1'b0, 1, 0);
        end

        // R7: uncached access to a cached line still bypasses; new uncached line not allocated.
        access({20'h0, 7'd9, 5'd12}, 20'h00109, 1'b1, 1, 1);
        access({20'h0, 7'd9, 5'd12}, 20'h00109, 1'b0, 0, 0);
        access({20'h0, 7'd10, 5'd0}, 20'h07777, 1'b1, 0, 2);
        access({20'h0, 7'd10, 5'd0}, 20'h07777, 1'b0, 0, 0);
        access({20'h0, 7'd10, 5'd0}, 20'h07777, 1'b0, 0, 0);

        // R8: stray translation and refill strobes in idle.
        @(negedge clk);
        xlat_valid = 1'b1; xlat_ppn = 20'h00103; fill_valid = 1'b1;
        fill_data = {8{32'hDEADBEEF}};
        @(negedge clk);
        xlat_valid = 1'b0; fill_valid = 1'b0;
        chk(!rsp_valid && !miss_valid && !req_stall, "R8 stray strobes ignored",
            {29'b0, req_stall, rsp_valid, miss_valid}, 0);
        @(negedge clk);
        chk(!rsp_valid && !miss_valid, "R8 no delayed output", {30'b0, rsp_valid, miss_valid}, 0);
        access({20'h0, 7'd3, 5'd20}, 20'h00103, 1'b0, 1, 0);
        // R8: stray refill during translation wait is ignored (checked inside via miss expectation).
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {20'h0, 7'd4, 5'd0};
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b1; fill_data = '0;
        @(negedge clk);
        fill_valid = 1'b0;
        chk(!rsp_valid && req_stall, "R8 refill while translating ignored",
            {30'b0, req_stall, rsp_valid}, 32'h2);
        xlat_valid = 1'b1; xlat_ppn = 20'h00104;
        @(negedge clk);
        xlat_valid = 1'b0;
        chk(rsp_valid && rsp_data == fword(20'h00104, 7'd4, 3'd0, 1'b0), "R8 later hit intact",
            rsp_data, fword(20'h00104, 7'd4, 3'd0, 1'b0));

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule